// File: doc/BRIEF.md
# UART Receive Status and Error Flag Controller

This block sits between a UART receive shifter and a small receive word buffer. The shifter hands over each finished character as a one-cycle strobe. The strobe carries the data byte, the sampled stop bit, the result of the parity comparison and a noise indication. The controller decides whether the character enters the buffer. It keeps a parity-error tag with every buffered word and maintains five sticky status flags: overrun, noise, framing, parity and idle. It also derives the data-ready indication.

Software reaches the block through a simple read bus with three locations. Address 0 is the status byte. Address 1 is the data register, and a read there pops the head word. Address 2 is the parity tag of the head word. A flag is cleared by a status read while the flag is set, followed by a data read. Overrun is the dominant condition: it drops characters, hides data-ready and stops the other flags and idle from rising.

Top module: `uart_rx_status_ctrl`

## Requirements
- R1: A character that completes while the overrun flag is clear, the framing flag is clear and the buffer holds fewer than 4 words is stored. A read of address 1 returns the oldest stored word in bits 7:0 and removes it. A read of address 1 on an empty buffer removes nothing.
- R2: A character that completes while the buffer already holds 4 words sets the overrun flag and is discarded. The same happens when break detection is enabled and the break-pending input is high. The words already buffered are kept unchanged and in order.
- R3: The character that causes an overrun never sets the noise, framing or parity flag, whatever its stop, noise and parity inputs are.
- R4: While the overrun flag is set, every completing character is discarded, even when the buffer has room. data_ready stays low, and the idle flag cannot rise.
- R5: With break detection disabled, a stored character whose stop bit was sampled as 0 sets the framing flag. While the framing flag is set, completing characters are ignored entirely: they are not stored and they set no flag.
- R6: With break detection disabled, the noise flag sets for a stored character that carries the noise indication. The parity flag sets only when parity checking is enabled and the parity comparison failed. Both flags stay set over any number of later clean characters.
- R7: With break detection enabled, neither the noise flag nor the framing flag is ever set, and no parity tag is recorded.
- R8: A status read records the flags that are set at that moment. The next read of address 1 clears exactly those flags. A flag that sets after the status read, or in the same cycle as the data read, stays set.
- R9: Every stored word keeps its own parity-error tag. A read of address 2 returns the head word's tag in bit 0 without removing the word.
- R10: The status byte holds parity in bit 0, framing in bit 1, noise in bit 2, overrun in bit 3, idle in bit 4 and data-ready in bit 5. Bits 7:6 read as 0. data_ready is high exactly when the buffer is non-empty and overrun is clear.
- R11: An idle-detect pulse sets the idle flag when overrun is clear. The idle flag is cleared by the same status-then-data read sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_done | input | 1 | One-cycle strobe: a character has finished its stop bit |
| char_data | input | 8 | Received data byte |
| stop_bit | input | 1 | Sampled stop-bit level |
| noise_seen | input | 1 | Noise detected during the character |
| parity_bad | input | 1 | Received parity bit disagrees with the computed one |
| parity_en | input | 1 | Parity checking enabled |
| brk_en | input | 1 | Break detection enabled |
| brk_pending | input | 1 | Break-detected flag still uncleared |
| idle_det | input | 1 | Idle-line detection pulse |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read address: 0 status, 1 data, 2 tag |
| rd_data | output | 8 | Read data for rd_addr |
| data_ready | output | 1 | Buffer non-empty and no overrun |
| ovr_flag | output | 1 | Overrun flag |
| noise_flag | output | 1 | Noise flag |
| frame_flag | output | 1 | Framing error flag |
| parity_flag | output | 1 | Parity error flag |
| idle_flag | output | 1 | Idle flag |

## Verification
Two collisions in a single cycle matter here. In the first, a character completes while a data read is in progress. The bench arms the noise flag with a status read, then raises char_done carrying noise in the same cycle as the data read. It expects the flag to survive, the old head to leave and the new word to enter. In the second, a flag sets between the status read and the data read. The bench expects that flag to outlive the data read and to clear only after a second status-then-data sequence.

// File: rtl/uart_rxflag_pkg.sv
package uart_rxflag_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_STAT = 2'd0,
        ADDR_DATA = 2'd1,
        ADDR_TAG  = 2'd2
    } reg_addr_e;

    typedef struct packed {
        logic idle;
        logic ovr;
        logic nf;
        logic fe;
        logic pf;
    } rx_flags_t;

    localparam int unsigned FLAG_N = $bits(rx_flags_t);

    typedef struct packed {
        logic              perr;
        logic [DATA_W-1:0] data;
    } rx_word_t;

    localparam int unsigned WORD_W = $bits(rx_word_t);

    function automatic logic [DATA_W-1:0] pack_status(rx_flags_t f, logic ready);
        logic [DATA_W-1:0] s;
        s    = '0;
        s[0] = f.pf;
        s[1] = f.fe;
        s[2] = f.nf;
        s[3] = f.ovr;
        s[4] = f.idle;
        s[5] = ready;
        return s;
    endfunction

endpackage

// File: rtl/rx_word_fifo.sv
module rx_word_fifo #(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned WORD_W = 9,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [WORD_W-1:0] push_word,
    input  logic              pop,
    output logic [WORD_W-1:0] head_word,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty
);
    logic [WORD_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full      = (count == CNT_W'(DEPTH));
    assign empty     = (count == '0);
    assign do_push   = push && !full;
    assign do_pop    = pop && !empty;
    assign head_word = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/rx_char_judge.sv
module rx_char_judge
    import uart_rxflag_pkg::*;
(
    input  logic      char_done,
    input  logic      stop_bit,
    input  logic      noise_seen,
    input  logic      parity_bad,
    input  logic      parity_en,
    input  logic      brk_en,
    input  logic      brk_pending,
    input  logic      idle_det,
    input  logic      fifo_full,
    input  rx_flags_t cur,
    output logic      store,
    output logic      perr_tag,
    output rx_flags_t set_req
);
    logic dropping;

    always_comb begin
        set_req  = '0;
        store    = 1'b0;
        perr_tag = parity_en && !brk_en && parity_bad;
        dropping = cur.ovr || fifo_full || (brk_en && brk_pending);
        set_req.idle = idle_det && !cur.ovr;
        if (char_done && !cur.fe) begin
            if (dropping) begin
                set_req.ovr = 1'b1;
            end else begin
                store      = 1'b1;
                set_req.nf = noise_seen && !brk_en;
                set_req.fe = !stop_bit && !brk_en;
                set_req.pf = perr_tag;
            end
        end
    end
endmodule

// File: rtl/rx_flag_bank.sv
module rx_flag_bank
    import uart_rxflag_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  rx_flags_t set_req,
    input  logic      stat_rd,
    input  logic      data_rd,
    output rx_flags_t flags
);
    logic [FLAG_N-1:0] flag_q, arm_q, clr_v;

    assign clr_v = data_rd ? arm_q : '0;
    assign flags = rx_flags_t'(flag_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            arm_q  <= '0;
        end else begin
            flag_q <= (flag_q & ~clr_v) | FLAG_N'(set_req);
            if (stat_rd)      arm_q <= flag_q;
            else if (data_rd) arm_q <= '0;
        end
    end
endmodule

// File: rtl/uart_rx_status_ctrl.sv
module uart_rx_status_ctrl
    import uart_rxflag_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 4,
    localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              char_done,
    input  logic [DATA_W-1:0] char_data,
    input  logic              stop_bit,
    input  logic              noise_seen,
    input  logic              parity_bad,
    input  logic              parity_en,
    input  logic              brk_en,
    input  logic              brk_pending,
    input  logic              idle_det,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              data_ready,
    output logic              ovr_flag,
    output logic              noise_flag,
    output logic              frame_flag,
    output logic              parity_flag,
    output logic              idle_flag
);
    rx_flags_t       flags, set_req;
    rx_word_t        head, in_word;
    logic            store, perr_tag, full, empty, stat_rd, data_rd;
    logic [CNT_W-1:0] fill_cnt;

    assign stat_rd = rd_en && (rd_addr == ADDR_STAT);
    assign data_rd = rd_en && (rd_addr == ADDR_DATA);

    rx_char_judge judge_i (
        .char_done  (char_done),
        .stop_bit   (stop_bit),
        .noise_seen (noise_seen),
        .parity_bad (parity_bad),
        .parity_en  (parity_en),
        .brk_en     (brk_en),
        .brk_pending(brk_pending),
        .idle_det   (idle_det),
        .fifo_full  (full),
        .cur        (flags),
        .store      (store),
        .perr_tag   (perr_tag),
        .set_req    (set_req)
    );

    always_comb begin
        in_word.perr = perr_tag;
        in_word.data = char_data;
    end

    rx_word_fifo #(.DEPTH(FIFO_DEPTH), .WORD_W(WORD_W)) fifo_i (
        .clk      (clk),
        .rst      (rst),
        .push     (store),
        .push_word(in_word),
        .pop      (data_rd),
        .head_word(head),
        .count    (fill_cnt),
        .full     (full),
        .empty    (empty)
    );

    rx_flag_bank bank_i (
        .clk    (clk),
        .rst    (rst),
        .set_req(set_req),
        .stat_rd(stat_rd),
        .data_rd(data_rd),
        .flags  (flags)
    );

    assign data_ready  = !empty && !flags.ovr;
    assign ovr_flag    = flags.ovr;
    assign noise_flag  = flags.nf;
    assign frame_flag  = flags.fe;
    assign parity_flag = flags.pf;
    assign idle_flag   = flags.idle;

    always_comb begin
        unique case (rd_addr)
            ADDR_STAT: rd_data = pack_status(flags, data_ready);
            ADDR_DATA: rd_data = head.data;
            ADDR_TAG:  rd_data = {{(DATA_W-1){1'b0}}, head.perr && !empty};
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/uart_rx_status_chk.sv
module uart_rx_status_chk #(
    parameter int unsigned FIFO_DEPTH = 4,
    localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             char_done,
    input logic             brk_en,
    input logic             rd_en,
    input logic [1:0]       rd_addr,
    input logic             data_ready,
    input logic             ovr_flag,
    input logic             noise_flag,
    input logic             frame_flag,
    input logic             parity_flag,
    input logic             idle_flag,
    input logic [CNT_W-1:0] fill
);
    assert_fill_bound_R2: assert property (@(posedge clk) disable iff (rst)
        fill <= CNT_W'(FIFO_DEPTH));

    assert_ovr_alone_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_flag) |-> (!$rose(noise_flag) && !$rose(frame_flag) && !$rose(parity_flag)));

    assert_ovr_no_store_R4: assert property (@(posedge clk) disable iff (rst)
        (ovr_flag && char_done) |=> (fill <= $past(fill)));

    assert_ovr_hides_ready_R4: assert property (@(posedge clk) disable iff (rst)
        ovr_flag |-> !data_ready);

    assert_ovr_blocks_idle_R4: assert property (@(posedge clk) disable iff (rst)
        ovr_flag |=> !$rose(idle_flag));

    assert_fe_blocks_rx_R5: assert property (@(posedge clk) disable iff (rst)
        (frame_flag && char_done) |=> (fill <= $past(fill)));

    assert_brk_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (brk_en && char_done) |=> (!$rose(noise_flag) && !$rose(frame_flag)));

    assert_clear_by_data_read_R8: assert property (@(posedge clk) disable iff (rst)
        ($fell(noise_flag) || $fell(frame_flag) || $fell(parity_flag) ||
         $fell(ovr_flag) || $fell(idle_flag)) |-> $past(rd_en && rd_addr == 2'd1));
endmodule

bind uart_rx_status_ctrl uart_rx_status_chk #(.FIFO_DEPTH(FIFO_DEPTH)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .char_done  (char_done),
    .brk_en     (brk_en),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .data_ready (data_ready),
    .ovr_flag   (ovr_flag),
    .noise_flag (noise_flag),
    .frame_flag (frame_flag),
    .parity_flag(parity_flag),
    .idle_flag  (idle_flag),
    .fill       (fill_cnt)
);

// File: tb/uart_rx_status_ctrl_tb.sv
module uart_rx_status_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       char_done = 0, stop_bit = 1, noise_seen = 0, parity_bad = 0;
    logic       parity_en = 0, brk_en = 0, brk_pending = 0, idle_det = 0;
    logic       rd_en = 0;
    logic [1:0] rd_addr = 0;
    logic [7:0] char_data = 0;
    logic [7:0] rd_data;
    logic       data_ready, ovr_flag, noise_flag, frame_flag, parity_flag, idle_flag;
    int         tests = 0, fails = 0;
    logic       done = 0;

    always #5 clk = ~clk;

    uart_rx_status_ctrl dut_i (
        .clk(clk), .rst(rst), .char_done(char_done), .char_data(char_data),
        .stop_bit(stop_bit), .noise_seen(noise_seen), .parity_bad(parity_bad),
        .parity_en(parity_en), .brk_en(brk_en), .brk_pending(brk_pending),
        .idle_det(idle_det), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .data_ready(data_ready), .ovr_flag(ovr_flag), .noise_flag(noise_flag),
        .frame_flag(frame_flag), .parity_flag(parity_flag), .idle_flag(idle_flag)
    );

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int st(input bit rdy, idl, ovr, nf, fe, pf);
        return (int'(rdy) << 5) | (int'(idl) << 4) | (int'(ovr) << 3) |
               (int'(nf) << 2) | (int'(fe) << 1) | int'(pf);
    endfunction

    task automatic send(input logic [7:0] d, input logic stp, nz, pb);
        char_data = d; stop_bit = stp; noise_seen = nz; parity_bad = pb; char_done = 1;
        tick();
        char_done = 0; stop_bit = 1; noise_seen = 0; parity_bad = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        rd_addr = a; rd_en = 1; #1 v = rd_data;
        tick();
        rd_en = 0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        rd_addr = a; #1 v = rd_data;
    endtask

    task automatic clear_all();
        logic [7:0] v;
        for (int k = 0; k < 5; k++) rd(2'd1, v);
        rd(2'd0, v);
        rd(2'd1, v);
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) tick();
        rst = 0;
        tick();
        peek(2'd0, v);
        chk("R10 reset status", v, 0);
        chk("R10 reset ready", data_ready, 0);

        // Sweep every combination of parity enable, break enable, stop, noise, parity result
        for (int i = 0; i < 32; i++) begin
            bit pen, bke, stp, nz, pb, e_nf, e_fe, e_pf;
            logic [7:0] d;
            {pen, bke, stp, nz, pb} = 5'(i);
            d = 8'(i * 7 + 3);
            parity_en = pen; brk_en = bke;
            e_nf = nz && !bke;
            e_fe = !stp && !bke;
            e_pf = pen && !bke && pb;
            send(d, stp, nz, pb);
            peek(2'd0, v);
            chk("R6/R7/R5 flags after one character", v, st(1, 0, 0, e_nf, e_fe, e_pf));
            peek(2'd2, v);
            chk("R9 tag of head word", v, int'(e_pf));
            rd(2'd0, v);
            rd(2'd1, v);
            chk("R1 data read returns stored byte", v, d);
            peek(2'd0, v);
            chk("R8 flags cleared by status then data read", v, 0);
        end
        parity_en = 1; brk_en = 0;

        // Overrun from a full buffer
        for (int k = 0; k < 4; k++) send(8'hA0 + 8'(k), 1, 0, 0);
        peek(2'd0, v);
        chk("R10 full buffer ready", v, st(1, 0, 0, 0, 0, 0));
        send(8'hEE, 0, 1, 1);
        peek(2'd0, v);
        chk("R2/R3 overrun alone, other flags untouched", v, st(0, 0, 1, 0, 0, 0));
        chk("R4 data_ready hidden during overrun", data_ready, 0);
        rd(2'd1, v);
        chk("R2 head word kept after overrun", v, 8'hA0);
        send(8'h99, 1, 0, 0);
        idle_det = 1; tick(); idle_det = 0;
        peek(2'd0, v);
        chk("R4 idle blocked and overrun stays after bare data read", v, st(0, 0, 1, 0, 0, 0));
        rd(2'd0, v);
        rd(2'd1, v);
        chk("R2 second buffered word", v, 8'hA1);
        peek(2'd0, v);
        chk("R8 overrun cleared, ready returns", v, st(1, 0, 0, 0, 0, 0));
        rd(2'd1, v);
        chk("R2 third buffered word", v, 8'hA2);
        rd(2'd1, v);
        chk("R4 word sent during overrun was dropped", v, 8'hA3);
        peek(2'd0, v);
        chk("R1 buffer empty afterwards", v, 0);
        rd(2'd1, v);
        peek(2'd0, v);
        chk("R1 empty data read harmless", v, 0);

        // Status read arms only the flags set at that moment
        rd(2'd0, v);
        send(8'h31, 1, 1, 0);
        rd(2'd1, v);
        chk("R1 byte of late-noise word", v, 8'h31);
        peek(2'd0, v);
        chk("R8 late noise survives data read", v, st(0, 0, 0, 1, 0, 0));
        rd(2'd0, v);
        rd(2'd1, v);
        peek(2'd0, v);
        chk("R8 noise cleared on second sequence", v, 0);

        // Set and clear in the same cycle
        send(8'h11, 1, 1, 0);
        rd(2'd0, v);
        rd_addr = 2'd1; rd_en = 1;
        char_data = 8'h22; noise_seen = 1; stop_bit = 1; char_done = 1;
        tick();
        rd_en = 0; char_done = 0; noise_seen = 0;
        peek(2'd0, v);
        chk("R8 set wins over clear in same cycle", v, st(1, 0, 0, 1, 0, 0));
        rd(2'd0, v);
        rd(2'd1, v);
        chk("R1 simultaneous push and pop", v, 8'h22);
        peek(2'd0, v);
        chk("R8 all clear after collision", v, 0);

        // Framing blocks reception
        send(8'h55, 0, 0, 0);
        send(8'h66, 1, 1, 1);
        peek(2'd0, v);
        chk("R5 framing set, next char ignored", v, st(1, 0, 0, 0, 1, 0));
        rd(2'd1, v);
        chk("R5 framed word stored", v, 8'h55);
        peek(2'd0, v);
        chk("R5 ignored char not stored", v, st(0, 0, 0, 0, 1, 0));
        rd(2'd0, v);
        rd(2'd1, v);
        peek(2'd0, v);
        chk("R5 framing cleared", v, 0);

        // Break pending forces overrun
        brk_en = 1; brk_pending = 1;
        send(8'h77, 0, 1, 1);
        peek(2'd0, v);
        chk("R2/R7 break-pending overrun", v, st(0, 0, 1, 0, 0, 0));
        brk_pending = 0; brk_en = 0;
        clear_all();
        peek(2'd0, v);
        chk("R2 nothing stored on break overrun", v, 0);

        // Per-word parity tags
        send(8'h01, 1, 0, 1);
        send(8'h02, 1, 0, 0);
        send(8'h03, 1, 0, 1);
        for (int k = 0; k < 3; k++) begin
            peek(2'd2, v);
            chk("R9 per-word tag", v, (k == 1) ? 0 : 1);
            rd(2'd1, v);
            chk("R9 word order", v, k + 1);
        end
        peek(2'd0, v);
        chk("R6 parity stays sticky", v, st(0, 0, 0, 0, 0, 1));
        clear_all();

        // Idle flag
        idle_det = 1; tick(); idle_det = 0;
        peek(2'd0, v);
        chk("R11 idle set", v, st(0, 1, 0, 0, 0, 0));
        rd(2'd0, v);
        rd(2'd1, v);
        peek(2'd0, v);
        chk("R11 idle cleared", v, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        done = 1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule